// File: doc/BRIEF.md
# Weighted and Transition-Density Scan Pattern Source

This block feeds a scan chain with pseudo-random serial test data for built-in self-test. On every enabled shift cycle it emits one scan-in bit. A mode input selects one of three statistics. Plain bits are ones half the time. Weighted bits are ones with a probability of k/10. Transition-density bits differ from the previous output bit with a probability of k/10.

A 16-bit maximal-length Fibonacci LFSR supplies the raw randomness. It advances sixteen steps per shift so that each output bit draws on fresh state. A ten-level value formed from twelve LFSR bits is compared against k to form the weighted bit. In transition-density mode the weighted bit toggles the output flip-flop rather than driving it directly. The weight input may be changed between scan loads to mix several weights or densities in one session, without a reset.

Top module: `wtg_pattern_gen`

## Requirements
- R1: Reset is synchronous and active high. While reset is asserted, the register holding scan_out is cleared to 0 and the generator state is set to 16'hACE1.
- R2: When shift_en is low and seed_load is low, scan_out and the generator state hold their values. Resuming continues the same bit sequence.
- R3: A high on seed_load loads seed_val into the generator and takes priority over shift_en. In that cycle no shift happens. Loading the same seed twice yields identical following bit streams.
- R4: An all-zero seed_val is replaced by 16'hACE1. The resulting stream equals the stream produced from seed 16'hACE1.
- R5: In plain mode (mode_sel 2'b00, and 2'b11, which is treated the same), each shift outputs bit 15 of the generator state. Over 10,000 shifts the ones fraction is within 0.03 of 0.5.
- R6: In weighted mode (mode_sel 2'b01), weight_sel = k gives a ones fraction within 0.03 of k/10 over 10,000 shifts. Values of weight_sel above 10 act as 10.
- R7: In weighted mode, k = 0 yields only zeros and k >= 10 yields only ones.
- R8: In transition-density mode (mode_sel 2'b10), the fraction of shifts whose bit differs from the previous output bit is within 0.03 of k/10 over 10,000 shifts.
- R9: In transition-density mode, k = 0 keeps scan_out constant and k >= 10 toggles it on every shift.
- R10: A change of weight_sel takes effect on the very next shift, with no reset or reload.
- R11: The generator is a Fibonacci LFSR with polynomial x^16+x^14+x^13+x^11+1. Each step shifts left and inserts as bit 0 the XOR of bits 15, 13, 12 and 10. A shift applies 16 steps after the output bit is taken from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advance one scan bit this cycle |
| seed_load | input | 1 | Load seed_val into the generator |
| seed_val | input | 16 | Seed value; zero is replaced by 16'hACE1 |
| mode_sel | input | 2 | 00/11 plain, 01 weighted, 10 transition density |
| weight_sel | input | 4 | Weight k in tenths, saturated at 10 |
| scan_out | output | 1 | Serial scan-in bit, registered |

## Verification
Plain mode is checked bit by bit against an arithmetic model of the polynomial and 16-step leap from a known seed. This separates tap, direction and leap errors from purely statistical ones. Long weighted and transition-density runs at several k values measure the ones and toggle fractions. A wrong comparison bound or a wrong mode mapping shows up as a fraction off by at least 0.1. The endpoints k = 0, k = 10 and a saturated k = 13 must be exact, which exposes off-by-one compares. Repeated and zero seeds, paused shifting and a mid-stream weight change show whether state is held, substituted and re-sampled correctly.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

    localparam int          LFSR_W     = 16;
    localparam logic [15:0] LFSR_TAPS  = 16'hB400;
    localparam logic [15:0] LFSR_SAFE  = 16'hACE1;
    localparam int          LEAP       = 16;
    localparam int          WEIGHT_W   = 4;
    localparam int          WEIGHT_TOP = 10;
    localparam int          DEC_BITS   = 12;

    typedef enum logic [1:0] {
        MODE_PLAIN    = 2'b00,
        MODE_WEIGHTED = 2'b01,
        MODE_TDEN     = 2'b10,
        MODE_ALT      = 2'b11
    } mode_e;

    typedef struct packed {
        logic plain;
        logic weighted;
    } raw_bits_t;

    function automatic logic [WEIGHT_W-1:0] clamp_weight(input logic [WEIGHT_W-1:0] k);
        if (k > WEIGHT_W'(WEIGHT_TOP))
            return WEIGHT_W'(WEIGHT_TOP);
        return k;
    endfunction

endpackage

// File: rtl/wtg_lfsr.sv
module wtg_lfsr #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter logic [W-1:0]   SAFE  = 16'hACE1,
    parameter int             STEPS = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;
    logic [W-1:0] chain [STEPS+1];

    assign chain[0] = state_q;

    generate
        for (genvar g = 0; g < STEPS; g++) begin : g_step
            assign chain[g+1] = {chain[g][W-2:0], ^(chain[g] & TAPS)};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SAFE;
        else if (load)
            state_q <= (seed == '0) ? SAFE : seed;
        else if (adv)
            state_q <= chain[STEPS];
    end

    assign state = state_q;

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R2
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(state_q));

    // R3
    lfsr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> (state_q == $past(seed)));

endmodule

// File: rtl/wtg_weight.sv
module wtg_weight
    import wtg_pkg::*;
#(
    parameter int W      = 16,
    parameter int DBITS  = 12,
    parameter int KW     = 4,
    parameter int KTOP   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  state,
    input  logic [KW-1:0] weight,
    output raw_bits_t     bits
);
    localparam int PW = DBITS + KW;

    logic [PW-1:0]  prod;
    logic [KW-1:0]  level;
    logic [KW-1:0]  k_sat;

    always_comb begin
        prod  = PW'(state[DBITS-1:0]) * PW'(KTOP);
        level = prod[PW-1 -: KW];
        k_sat = (weight > KW'(KTOP)) ? KW'(KTOP) : weight;
        bits.plain    = state[W-1];
        bits.weighted = (level < k_sat);
    end

    // R7
    weight_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (weight == '0) |-> !bits.weighted);

    // R7
    weight_full_chk: assert property (@(posedge clk) disable iff (rst)
        (weight >= KW'(KTOP)) |-> bits.weighted);

endmodule

// File: rtl/wtg_shaper.sv
module wtg_shaper
    import wtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  mode_e     mode,
    input  raw_bits_t bits,
    output logic      out
);
    logic out_q;
    logic nxt;

    always_comb begin
        unique case (mode)
            MODE_WEIGHTED: nxt = bits.weighted;
            MODE_TDEN:     nxt = out_q ^ bits.weighted;
            default:       nxt = bits.plain;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else if (adv)
            out_q <= nxt;
    end

    assign out = out_q;

    // R1
    shaper_reset_chk: assert property (@(posedge clk)
        rst |=> !out_q);

    // R2
    shaper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(out_q));

endmodule

// File: rtl/wtg_pattern_gen.sv
module wtg_pattern_gen
    import wtg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                seed_load,
    input  logic [LFSR_W-1:0]   seed_val,
    input  logic [1:0]          mode_sel,
    input  logic [WEIGHT_W-1:0] weight_sel,
    output logic                scan_out
);
    logic              adv;
    logic [LFSR_W-1:0] state;
    raw_bits_t         bits;
    mode_e             mode;

    assign adv  = shift_en & ~seed_load;
    assign mode = mode_e'(mode_sel);

    wtg_lfsr #(
        .W(LFSR_W), .TAPS(LFSR_TAPS), .SAFE(LFSR_SAFE), .STEPS(LEAP)
    ) u_lfsr (
        .clk(clk), .rst(rst), .adv(adv), .load(seed_load),
        .seed(seed_val), .state(state)
    );

    wtg_weight #(
        .W(LFSR_W), .DBITS(DEC_BITS), .KW(WEIGHT_W), .KTOP(WEIGHT_TOP)
    ) u_weight (
        .clk(clk), .rst(rst), .state(state), .weight(weight_sel), .bits(bits)
    );

    wtg_shaper u_shaper (
        .clk(clk), .rst(rst), .adv(adv), .mode(mode), .bits(bits), .out(scan_out)
    );

    // R9
    tden_full_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_TDEN && clamp_weight(weight_sel) == WEIGHT_W'(WEIGHT_TOP))
        |=> (scan_out != $past(scan_out)));

    // R9
    tden_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_TDEN && weight_sel == '0) |=> $stable(scan_out));

    // R3
    load_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> $stable(scan_out));

endmodule

// File: tb/sim_wtg_pattern_gen.sv
module sim_wtg_pattern_gen;
    localparam int CLK_HALF = 5;
    localparam int WDOG     = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shift_en = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic [1:0]  mode_sel = 2'b00;
    logic [3:0]  weight_sel = '0;
    logic        scan_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #CLK_HALF clk = ~clk;

    wtg_pattern_gen u0 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .seed_load(seed_load),
        .seed_val(seed_val), .mode_sel(mode_sel), .weight_sel(weight_sel),
        .scan_out(scan_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_leap(input logic [15:0] s);
        logic [15:0] t = s;
        for (int i = 0; i < 16; i++)
            t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]};
        return t;
    endfunction

    task automatic shift(output logic b);
        shift_en = 1'b1;
        @(negedge clk);
        b = scan_out;
    endtask

    task automatic load(input logic [15:0] s);
        shift_en  = 1'b0;
        seed_load = 1'b1;
        seed_val  = s;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    task automatic run(input logic [1:0] m, input logic [3:0] k, input int n,
                       output int ones, output int toggles);
        logic prev, b;
        mode_sel = m;
        weight_sel = k;
        ones = 0;
        toggles = 0;
        prev = scan_out;
        for (int i = 0; i < n; i++) begin
            shift(b);
            ones += int'(b);
            toggles += int'(b != prev);
            prev = b;
        end
        shift_en = 1'b0;
    endtask

    initial begin
        logic [63:0] a, c;
        logic [15:0] s;
        logic b, held;
        int ones, tog;

        // R1: shifting requested during reset, output must stay cleared
        shift_en = 1'b1; mode_sel = 2'b01; weight_sel = 4'd10;
        repeat (3) @(negedge clk);
        check(scan_out == 1'b0, "R1 out during reset", int'(scan_out), 0);
        rst = 1'b0; shift_en = 1'b0;
        @(negedge clk);
        check(scan_out == 1'b0, "R1 out after reset", int'(scan_out), 0);

        // R1/R11: first bits after reset follow the model from 16'hACE1
        s = 16'hACE1; mode_sel = 2'b00;
        for (int i = 0; i < 16; i++) begin
            shift(b);
            check(b == s[15], "R11 stream from reset state", int'(b), int'(s[15]));
            s = model_leap(s);
        end
        shift_en = 1'b0;

        // R11: plain stream from a loaded seed
        load(16'h1234);
        s = 16'h1234;
        for (int i = 0; i < 32; i++) begin
            shift(b);
            check(b == s[15], "R11 plain bit vs model", int'(b), int'(s[15]));
            s = model_leap(s);
        end
        shift_en = 1'b0;

        // R3: repeatable stream from same seed
        load(16'h5A5A);
        for (int i = 0; i < 64; i++) begin shift(b); a[i] = b; end
        load(16'h5A5A);
        for (int i = 0; i < 64; i++) begin shift(b); c[i] = b; end
        shift_en = 1'b0;
        check(a == c, "R3 same seed same stream", int'(a[31:0]), int'(c[31:0]));

        // R3: load has priority, no shift in that cycle
        held = scan_out;
        shift_en = 1'b1; seed_load = 1'b1; seed_val = 16'h0F0F;
        @(negedge clk);
        seed_load = 1'b0; shift_en = 1'b0;
        check(scan_out == held, "R3 load blocks shift", int'(scan_out), int'(held));
        s = 16'h0F0F;
        shift(b); shift_en = 1'b0;
        check(b == s[15], "R3 first bit after load", int'(b), int'(s[15]));

        // R4: zero seed substituted
        load(16'h0000);
        for (int i = 0; i < 64; i++) begin shift(b); a[i] = b; end
        load(16'hACE1);
        for (int i = 0; i < 64; i++) begin shift(b); c[i] = b; end
        shift_en = 1'b0;
        check(a == c, "R4 zero seed equals safe seed", int'(a[31:0]), int'(c[31:0]));
        check(a != '0, "R4 zero seed not stuck", int'(a[31:0]), 1);

        // R2: pause keeps output and continues sequence
        load(16'hBEEF);
        for (int i = 0; i < 8; i++) begin shift(b); a[i] = b; end
        load(16'hBEEF);
        for (int i = 0; i < 4; i++) begin shift(b); c[i] = b; end
        shift_en = 1'b0;
        held = scan_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(scan_out == held, "R2 hold while idle", int'(scan_out), int'(held));
        end
        for (int i = 4; i < 8; i++) begin shift(b); c[i] = b; end
        shift_en = 1'b0;
        check(a[7:0] == c[7:0], "R2 sequence continues", int'(c[7:0]), int'(a[7:0]));

        // R7: weighted endpoints, R6 saturation
        run(2'b01, 4'd0, 200, ones, tog);
        check(ones == 0, "R7 weight 0 all zeros", ones, 0);
        run(2'b01, 4'd10, 200, ones, tog);
        check(ones == 200, "R7 weight 10 all ones", ones, 200);
        run(2'b01, 4'd13, 200, ones, tog);
        check(ones == 200, "R6 weight 13 saturates", ones, 200);

        // R10: weight change takes effect next shift
        run(2'b01, 4'd0, 20, ones, tog);
        check(scan_out == 1'b0, "R10 before change", int'(scan_out), 0);
        weight_sel = 4'd10;
        shift(b); shift_en = 1'b0;
        check(b == 1'b1, "R10 after change", int'(b), 1);

        // R9: transition endpoints
        run(2'b10, 4'd0, 100, ones, tog);
        check(tog == 0, "R9 density 0 constant", tog, 0);
        run(2'b10, 4'd10, 100, ones, tog);
        check(tog == 100, "R9 density 10 toggles", tog, 100);
        run(2'b10, 4'd15, 50, ones, tog);
        check(tog == 50, "R9 density 15 saturates", tog, 50);

        // R5: plain statistics, both encodings
        load(16'h7A31);
        run(2'b00, 4'd3, 10000, ones, tog);
        check(ones >= 4700 && ones <= 5300, "R5 plain ones fraction", ones, 5000);
        run(2'b11, 4'd9, 10000, ones, tog);
        check(ones >= 4700 && ones <= 5300, "R5 alt mode ones fraction", ones, 5000);

        // R6: weighted statistics
        for (int k = 1; k <= 9; k += 2) begin
            run(2'b01, 4'(k), 10000, ones, tog);
            check(ones >= k*1000 - 300 && ones <= k*1000 + 300,
                  $sformatf("R6 weighted k=%0d", k), ones, k*1000);
        end

        // R8: transition-density statistics
        for (int k = 3; k <= 7; k += 2) begin
            run(2'b10, 4'(k), 10000, ones, tog);
            check(tog >= k*1000 - 300 && tog <= k*1000 + 300,
                  $sformatf("R8 density k=%0d", k), tog, k*1000);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule